// File: doc/BRIEF.md
# Pipelined Modular Coefficient Adder/Subtractor

This block combines two polynomial coefficients that are already reduced modulo the prime 3329. It returns their modular sum or their modular difference, and a mode bit chosen with each transaction selects which. The arithmetic runs through one shared adder. A single conditional correction step follows the adder, so every result lands in 0..3328.

The unit is one pipeline stage. An operand pair is taken on a clock edge when the input side is valid and the stage is ready. Its result is held in an output register with a valid flag until downstream takes it. The stage can accept a new pair in the same cycle that its current result is drained, so it streams at one result per clock when downstream never stalls. Reset is synchronous and active low.

Top module: `modq_addsub`

## Requirements
- R1: While `rstN` is low at a clock edge, the stage empties. After that edge `outValid` is 0 and `inReady` is 1.
- R2: With `subMode` = 0, an accepted pair yields (a + b) mod 3329. For example, 3328 + 3328 gives 3327 and 1664 + 1665 gives 0.
- R3: With `subMode` = 1, an accepted pair yields (a - b) mod 3329. For example, 0 - 1 gives 3328 and a - a gives 0.
- R4: A pair accepted on a clock edge is presented on `resOut`, with `outValid` high, directly after that same edge.
- R5: `inReady` is high exactly when `outReady` is high or `outValid` is low.
- R6: While `outValid` is high and `outReady` is low, no pair is accepted, and `resOut` and `outValid` keep their values.
- R7: When the held result is taken (`outReady` high) and no new pair is offered, `outValid` goes low after that edge.
- R8: When the held result is taken and a new pair is accepted on the same edge, `outValid` stays high and `resOut` shows the new result.
- R9: For reduced operands, `resOut` is always below 3329.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| aIn | input | 12 | First operand, below 3329 |
| bIn | input | 12 | Second operand, below 3329 |
| subMode | input | 1 | 0 = sum, 1 = difference |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Stage can take a pair this cycle |
| resOut | output | 12 | Reduced result |
| outValid | output | 1 | `resOut` holds an untaken result |
| outReady | input | 1 | Downstream takes the result this cycle |

## Verification
Draining the held result and accepting a new pair can fall on the same clock edge. The bench forces this by offering pairs back to back while `outReady` stays high. It passes only if `outValid` never drops and `resOut` shows each new result one edge after it was offered. A stall cycle also falls on a cycle with a pending offer. There the bench expects `inReady` low, an unchanged result and an unchanged flag. It then checks that the same offer is taken once the stall is lifted.

// File: rtl/modq_addsub_pkg.sv
package modq_addsub_pkg;
  parameter int COEF_W  = 12;
  parameter int MODULUS = 3329;

  // Strobes from the handshake control to the arithmetic datapath.
  typedef struct packed {
    logic load;
  } dpCtrl_t;
endpackage

// File: rtl/modq_addsub_ctrl.sv
module modq_addsub_ctrl
  import modq_addsub_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output dpCtrl_t ctrl
);
  logic validQ;
  logic accept;

  assign inReady   = outReady | ~validQ;
  assign accept    = inValid & inReady;
  assign ctrl.load = accept;
  assign outValid  = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)          validQ <= 1'b0;
    else if (accept)    validQ <= 1'b1;
    else if (outReady)  validQ <= 1'b0;
  end

  // R4: an accepted pair is presented on the following cycle
  assert_accept_shows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R6: a stalled result keeps its valid flag
  assert_stall_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R7: draining with nothing offered empties the stage
  assert_drain_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);
endmodule

// File: rtl/modq_addsub_dp.sv
module modq_addsub_dp
  import modq_addsub_pkg::*;
#(
  parameter int CW  = COEF_W,
  parameter int MOD = MODULUS
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctrl,
  input  logic [CW-1:0] aIn,
  input  logic [CW-1:0] bIn,
  input  logic          subMode,
  output logic [CW-1:0] resOut
);
  localparam int SW = CW + 1;
  localparam logic [SW-1:0] MOD_V = SW'(MOD);

  logic [SW-1:0] aExt, bExt, bOp, rawRes, fixRes;
  logic          needFix;
  logic [CW-1:0] nextRes;

  // One shared adder: subtraction as a + ~b + 1.
  always_comb begin
    aExt   = {1'b0, aIn};
    bExt   = {1'b0, bIn};
    bOp    = subMode ? ~bExt : bExt;
    rawRes = aExt + bOp + SW'(subMode);
    if (subMode) begin
      needFix = rawRes[SW-1];
      fixRes  = rawRes + MOD_V;
    end else begin
      needFix = (rawRes >= MOD_V);
      fixRes  = rawRes - MOD_V;
    end
    nextRes = needFix ? fixRes[CW-1:0] : rawRes[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          resOut <= '0;
    else if (ctrl.load) resOut <= nextRes;
  end

  // R9: the held result is always fully reduced
  assert_reduced_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (resOut < CW'(MOD)));

  // R6: with no load strobe the result register does not move
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(resOut));
endmodule

// File: rtl/modq_addsub.sv
module modq_addsub
  import modq_addsub_pkg::*;
#(
  parameter int CW  = COEF_W,
  parameter int MOD = MODULUS
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] aIn,
  input  logic [CW-1:0] bIn,
  input  logic          subMode,
  input  logic          inValid,
  output logic          inReady,
  output logic [CW-1:0] resOut,
  output logic          outValid,
  input  logic          outReady
);
  dpCtrl_t ctrl;

  modq_addsub_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .ctrl(ctrl)
  );

  modq_addsub_dp #(.CW(CW), .MOD(MOD)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .aIn(aIn), .bIn(bIn),
    .subMode(subMode), .resOut(resOut)
  );
endmodule

// File: tb/test_modq_addsub.sv
module test_modq_addsub;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] aIn, bIn;
  logic        subMode, inValid, outReady;
  logic        inReady, outValid;
  logic [11:0] resOut;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  modq_addsub i_modq_addsub (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn), .subMode(subMode),
    .inValid(inValid), .inReady(inReady), .resOut(resOut),
    .outValid(outValid), .outReady(outReady)
  );

  function automatic int expVal(input int a, input int b, input bit m);
    int r;
    if (!m) begin r = a + b; if (r >= 3329) r = r - 3329; end
    else    begin r = a - b; if (r < 0)     r = r + 3329; end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one pair with outReady high; check the result right after the edge.
  task automatic sendOp(input int a, input int b, input bit m, input string req);
    int e;
    e = expVal(a, b, m);
    @(negedge clk);
    aIn = 12'(a); bIn = 12'(b); subMode = m; inValid = 1'b1; outReady = 1'b1;
    @(posedge clk); #1;
    chk(outValid === 1'b1, {req, " valid"}, int'(outValid), 1);
    chk(resOut === 12'(e), req, int'(resOut), e);
    chk(resOut < 12'd3329, "R9 range", int'(resOut), 3328);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; aIn = '0; bIn = '0; subMode = 1'b0; inValid = 1'b0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid === 1'b0, "R1 valid after reset", int'(outValid), 0);
    chk(inReady === 1'b1, "R1 ready after reset", int'(inReady), 1);
    rstN = 1'b1;

    // Directed corners
    sendOp(3328, 3328, 1'b0, "R2 3328+3328");
    sendOp(1664, 1665, 1'b0, "R2 1664+1665");
    sendOp(0, 0, 1'b0, "R2 0+0");
    sendOp(0, 1, 1'b1, "R3 0-1");
    sendOp(1234, 1234, 1'b1, "R3 a-a");
    sendOp(3328, 0, 1'b1, "R3 3328-0");
    sendOp(0, 3328, 1'b1, "R3 0-3328");

    // R7: drain with nothing new
    @(negedge clk); inValid = 1'b0; outReady = 1'b1;
    @(posedge clk); #1;
    chk(outValid === 1'b0, "R7 drained", int'(outValid), 0);

    // R5 / R6: stall with a pending offer
    sendOp(100, 200, 1'b0, "R4 load before stall");
    @(negedge clk);
    aIn = 12'd5; bIn = 12'd7; subMode = 1'b1; inValid = 1'b1; outReady = 1'b0;
    #1;
    chk(inReady === 1'b0, "R5 ready low when full and stalled", int'(inReady), 0);
    @(posedge clk); #1;
    chk(outValid === 1'b1, "R6 valid held", int'(outValid), 1);
    chk(resOut === 12'd300, "R6 result held", int'(resOut), 300);
    @(negedge clk); outReady = 1'b1; #1;
    chk(inReady === 1'b1, "R5 ready when drained", int'(inReady), 1);
    // R8: same-edge drain and accept of the pending pair
    @(posedge clk); #1;
    chk(outValid === 1'b1, "R8 valid stays", int'(outValid), 1);
    chk(resOut === 12'd3327, "R8 new result", int'(resOut), 3327);
    @(negedge clk); inValid = 1'b0;
    @(posedge clk); #1;
    chk(outValid === 1'b0, "R7 drained again", int'(outValid), 0);

    // Constrained random, back to back (R2, R3, R8)
    for (int i = 0; i < 300; i++) begin
      int a, b; bit m;
      a = int'($urandom_range(0, 3328));
      b = int'($urandom_range(0, 3328));
      m = 1'($urandom_range(0, 1));
      sendOp(a, b, m, m ? "R3 random" : "R2 random");
    end

    // R1: reset while full empties the stage
    @(negedge clk); inValid = 1'b0; outReady = 1'b0; rstN = 1'b0;
    @(posedge clk); #1;
    chk(outValid === 1'b0, "R1 reset while full", int'(outValid), 0);
    chk(inReady === 1'b1, "R1 ready after mid reset", int'(inReady), 1);
    rstN = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule